// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This unit picks the smaller or larger of two 64-bit binary floating-point operands. The operands are handled as raw bit patterns, and no arithmetic is performed on them. The result is always one of the two inputs, or one of them with its quiet bit forced high. A 4-bit mode word controls three things: whether the minimum or the maximum is chosen, whether the magnitudes are compared before the signs, and which of four NaN conventions applies.

The unit also raises a flag when either operand is a signalling NaN. It drops its write-enable when that flag coincides with the trap-enable input, so the destination keeps its old value. Each operation occupies one register stage. A request presented with `in_valid` appears on the outputs with `out_valid` one clock later.

Mode encoding:
- Bit 3 chooses the direction: 1 selects the maximum, 0 selects the minimum.
- Bit 2 turns on the magnitude comparison.
- Bits 1:0 choose the NaN policy.

Top module: `fp_minmax_sel`

## Requirements
- R1: An operand is a NaN when its bits 62:0, read as unsigned, exceed 0x7FF0_0000_0000_0000. A NaN is signalling when bit 51 is 0. Quieting sets bit 51 and leaves every other bit unchanged.
- R2: NaN policy 00, with a NaN present:
  - a signalling a gives quieted a;
  - otherwise a signalling b gives quieted b;
  - otherwise two NaNs give quieted a;
  - otherwise the non-NaN operand is returned unchanged.
- R3: NaN policy 01: if a is a NaN the result is quieted a; otherwise the result is quieted b.
- R4: NaN policy 10: two NaNs give quieted a. A single NaN, signalling or quiet, gives the other operand unchanged.
- R5: NaN policy 11: any NaN input gives operand b unchanged.
- R6: Without NaNs, ordering is sign-magnitude and -0 is below +0. Minimum returns the smaller operand and maximum the larger. Equal operands return b.
- R7: With mode bit 2 set, operands whose magnitudes (bits 62:0) differ are ordered by magnitude alone. Equal magnitudes fall back to the signed ordering of R6.
- R8: Under policy 11, a zero of either sign is ordered as +0. Two zeros therefore return b.
- R9: The signalling-NaN flag and the summary exception flag are both 1 exactly when either operand is a signalling NaN, whatever the policy.
- R10: The write-enable output is 0 when trap-enable is 1 and a signalling NaN is present. Otherwise it is 1 for each valid result.
- R11: `out_valid` follows `in_valid` by one clock. Synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| mode | input | 4 | Mode: [3] max, [2] magnitude compare, [1:0] NaN policy |
| trap_en | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Selected value |
| snan_flag | output | 1 | Signalling-NaN invalid flag |
| exc_flag | output | 1 | Summary exception flag |
| wr_en | output | 1 | Result write-enable |

## Verification
Every output comes from the same single register stage, so all results of a request are due one clock after it is presented. The bench drives each request on a falling edge, with `in_valid` high. It compares the result, both flags, the write-enable and `out_valid` on the next falling edge, by which time exactly one rising edge has captured the request. The reset values are sampled on a falling edge, before the first request is presented.

// File: rtl/fp_minmax_sel.sv
module fp_minmax_sel #(
  parameter int W     = 64,
  parameter int QBIT  = 51,
  parameter logic [W-2:0] INF_MAG = 63'h7FF0_0000_0000_0000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   mode,
  input  logic         trap_en,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         snan_flag,
  output logic         exc_flag,
  output logic         wr_en
);

  localparam logic [W-1:0] QMASK = W'(1) << QBIT;

  logic [W-1:0] abs_a, abs_b, qa, qb;
  logic a_nan, b_nan, a_snan, b_snan, any_snan;

  assign abs_a  = {1'b0, op_a[W-2:0]};
  assign abs_b  = {1'b0, op_b[W-2:0]};
  assign a_nan  = op_a[W-2:0] > INF_MAG;
  assign b_nan  = op_b[W-2:0] > INF_MAG;
  assign a_snan = a_nan & ~op_a[QBIT];
  assign b_snan = b_nan & ~op_b[QBIT];
  assign any_snan = a_snan | b_snan;
  assign qa = op_a | QMASK;
  assign qb = op_b | QMASK;

  logic pick_max, use_mag, c_style;
  assign pick_max = mode[3];
  assign use_mag  = mode[2];
  assign c_style  = (mode[1:0] == 2'b11);

  logic [W-1:0] nan_res;
  always_comb begin
    unique case (mode[1:0])
      2'b00: begin
        if (a_snan)              nan_res = qa;
        else if (b_snan)         nan_res = qb;
        else if (a_nan && b_nan) nan_res = qa;
        else if (a_nan)          nan_res = op_b;
        else                     nan_res = op_a;
      end
      2'b01: nan_res = a_nan ? qa : qb;
      2'b10: begin
        if (a_nan && b_nan) nan_res = qa;
        else if (a_nan)     nan_res = op_b;
        else                nan_res = op_a;
      end
      default: nan_res = op_b;
    endcase
  end

  logic [W-1:0] lhs, rhs, cl, cr;
  logic take_a;
  always_comb begin
    lhs = op_a;
    rhs = op_b;
    if (use_mag && (abs_a != abs_b)) begin
      lhs = abs_a;
      rhs = abs_b;
    end
    if (c_style && abs_a == '0) lhs = '0;
    if (c_style && abs_b == '0) rhs = '0;
    cl = pick_max ? rhs : lhs;
    cr = pick_max ? lhs : rhs;
    if (cl[W-1])
      take_a = !cr[W-1] || (cl > cr);
    else
      take_a = !cr[W-1] && (cl < cr);
  end

  logic [W-1:0] sel;
  assign sel = (a_nan || b_nan) ? nan_res : (take_a ? op_a : op_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      snan_flag <= 1'b0;
      exc_flag  <= 1'b0;
      wr_en     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= sel;
        snan_flag <= any_snan;
        exc_flag  <= any_snan;
        wr_en     <= !(trap_en && any_snan);
      end else begin
        wr_en     <= 1'b0;
      end
    end
  end

  p_valid_lat_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !wr_en);
  p_operand_only_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (result == $past(op_a)) || (result == $past(op_b)) ||
                 (result == ($past(op_a) | QMASK)) || (result == ($past(op_b) | QMASK)));
  p_cstyle_nan_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && c_style && (a_nan || b_nan)) |=> result == $past(op_b));
  p_quiet_out_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[1:0] == 2'b01 && a_nan) |=> result[QBIT]);
  p_wren_cause_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wr_en) |-> snan_flag);
  p_flags_agree_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (snan_flag == exc_flag));

endmodule

// File: tb/tb_fp_minmax_sel.sv
module tb_fp_minmax_sel;
  logic clk = 0, rst = 1, in_valid = 0, trap_en = 0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [3:0] mode = '0;
  logic out_valid, snan_flag, exc_flag, wr_en;
  logic [63:0] result;
  int n_vec = 0, n_bad = 0;

  fp_minmax_sel dut (.clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .mode(mode), .trap_en(trap_en), .out_valid(out_valid), .result(result),
    .snan_flag(snan_flag), .exc_flag(exc_flag), .wr_en(wr_en));

  always #5 clk = ~clk;

  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] QN = 64'h7FF8_0000_0000_0001, SN = 64'h7FF0_0000_0000_0005;
  localparam logic [63:0] ONE = 64'h3FF0_0000_0000_0000, TWO = 64'h4000_0000_0000_0000;
  localparam logic [63:0] M1 = 64'hBFF0_0000_0000_0000, M2 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;

  function automatic bit is_nan(logic [63:0] x); return x[62:0] > 63'h7FF0_0000_0000_0000; endfunction
  function automatic bit is_sn(logic [63:0] x); return is_nan(x) && !x[51]; endfunction
  function automatic logic [63:0] quiet(logic [63:0] x); return {x[63:52], 1'b1, x[50:0]}; endfunction

  function automatic logic [63:0] okey(logic [63:0] x, bit cz);
    if (cz && x[62:0] == '0) x = '0;
    return x[63] ? ~x : {1'b1, x[62:0]};
  endfunction

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [3:0] m);
    bit an = is_nan(a), bn = is_nan(b), cz = (m[1:0] == 2'b11);
    bit a_wins;
    if (an || bn) begin
      case (m[1:0])
        2'b00: return is_sn(a) ? quiet(a) : is_sn(b) ? quiet(b) : (an && bn) ? quiet(a) : an ? b : a;
        2'b01: return an ? quiet(a) : quiet(b);
        2'b10: return (an && bn) ? quiet(a) : an ? b : a;
        default: return b;
      endcase
    end
    if (m[2] && a[62:0] != b[62:0])
      a_wins = m[3] ? (a[62:0] > b[62:0]) : (a[62:0] < b[62:0]);
    else
      a_wins = m[3] ? (okey(a, cz) > okey(b, cz)) : (okey(a, cz) < okey(b, cz));
    return a_wins ? a : b;
  endfunction

  function automatic string tag_of(logic [63:0] a, logic [63:0] b, logic [3:0] m);
    if (is_nan(a) || is_nan(b))
      case (m[1:0]) 2'b00: return "R2"; 2'b01: return "R3"; 2'b10: return "R4"; default: return "R5"; endcase
    if (m[1:0] == 2'b11 && a[62:0] == '0 && b[62:0] == '0) return "R8";
    if (m[2]) return "R7";
    return "R6";
  endfunction

  task automatic apply(logic [63:0] a, logic [63:0] b, logic [3:0] m, logic te);
    logic [63:0] exp_r;
    bit exp_sn, exp_we;
    string t;
    @(negedge clk);
    op_a = a; op_b = b; mode = m; trap_en = te; in_valid = 1;
    exp_r  = model(a, b, m);
    exp_sn = is_sn(a) || is_sn(b);
    exp_we = !(te && exp_sn);
    t = tag_of(a, b, m);
    @(negedge clk);
    in_valid = 0;
    n_vec++;
    if (result !== exp_r || snan_flag !== exp_sn || exc_flag !== exp_sn ||
        wr_en !== exp_we || out_valid !== 1'b1) begin
      n_bad++;
      if (result !== exp_r)
        $display("FAIL %s a=%h b=%h mode=%b result=%h expected=%h", t, a, b, m, result, exp_r);
      if (snan_flag !== exp_sn || exc_flag !== exp_sn)
        $display("FAIL R9 flags=%b%b expected=%b%b", snan_flag, exc_flag, exp_sn, exp_sn);
      if (wr_en !== exp_we)
        $display("FAIL R10 wr_en=%b expected=%b", wr_en, exp_we);
      if (out_valid !== 1'b1)
        $display("FAIL R11 out_valid=%b expected=1", out_valid);
    end
  endtask

  function automatic logic [63:0] rnd_val();
    logic [63:0] r = {$urandom, $urandom};
    case ($urandom % 8)
      0: return {r[63], 11'h7FF, 1'b1, r[50:0]};
      1: return {r[63], 11'h7FF, 1'b0, r[50:1], 1'b1};
      2: return {r[63], 63'h0};
      3: return {r[63], 63'h7FF0_0000_0000_0000};
      4: return {r[63], 11'h3FF, 52'h0};
      default: return r;
    endcase
  endfunction

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1B5E));
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 0 || result !== '0 || snan_flag !== 0 || exc_flag !== 0 || wr_en !== 0) begin
      n_bad++;
      $display("FAIL R11 reset state ov=%b r=%h f=%b%b we=%b expected all 0",
               out_valid, result, snan_flag, exc_flag, wr_en);
    end
    rst = 0;
    // R6 signed ordering, ties and signed zeros
    apply(ONE, TWO, 4'b0000, 0);
    apply(ONE, TWO, 4'b1000, 0);
    apply(M1, M2, 4'b0000, 0);
    apply(M1, M2, 4'b1000, 0);
    apply(NZ, PZ, 4'b0000, 0);
    apply(PZ, NZ, 4'b1000, 0);
    apply(ONE, ONE, 4'b0000, 0);
    // R7 magnitude compare, tie falls back to sign
    apply(M2, ONE, 4'b0100, 0);
    apply(M2, ONE, 4'b1100, 0);
    apply(M1, ONE, 4'b0100, 0);
    apply(M1, ONE, 4'b1100, 0);
    // R8 C-style zeros
    apply(NZ, PZ, 4'b0011, 0);
    apply(PZ, NZ, 4'b1011, 0);
    // R1/R2 policy 00
    apply(SN, QN, 4'b0000, 0);
    apply(QN, SN, 4'b0000, 0);
    apply(QN, ONE, 4'b0000, 0);
    apply(ONE, QN, 4'b1000, 0);
    // R3 policy 01
    apply(ONE, SN, 4'b0001, 0);
    apply(QN, ONE, 4'b0001, 0);
    // R4 policy 10
    apply(SN, ONE, 4'b0010, 0);
    apply(QN, SN, 4'b0010, 0);
    // R5 policy 11
    apply(SN, PINF, 4'b0011, 0);
    apply(ONE, QN, 4'b1111, 0);
    // R9/R10 trap enable
    apply(ONE, SN, 4'b0010, 1);
    apply(QN, ONE, 4'b0000, 1);
    repeat (3000) apply(rnd_val(), rnd_val(), 4'($urandom), 1'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule